// File: doc/BRIEF.md
# Circular Request List Engine

This block is the device side of a ring-based command interface. The host programs three memory locations: the base of an inbound list, the base of an outbound list, and a shadow word that receives the outbound copy pointer. The host then advances an inbound write pointer. The engine reads each newly posted inbound unit through a memory read port. A unit is one 64-bit word: the request address is in bits 31:0 and the request size is in bits 63:32. The engine hands each unit, in order, to a processing side through a valid/ready pair.

When the processing side reports a completion, the engine writes the completion flag into the next outbound unit. It then writes that unit's index into the shadow word and sets an interrupt cause bit. The host finds new completions by comparing the shadow word with its own read pointer, and the interrupt line is gated by an enable register. A mailbox pair carries commands that do not go through the rings. A host write to the command register is passed to the local CPU, and the CPU answers through a reply register that the host can read.

Both rings wrap at a request count that the host programs. Register offsets (byte addresses): inbound base low/high 0x4000/0x4004, inbound write pointer 0x4018, list control 0x402C, outbound base low/high 0x4050/0x4054, shadow base low/high 0x4058/0x405C, interrupt cause 0x4088, interrupt enable 0x408C, host-to-CPU command 0x10400, CPU-to-host reply 0x10420.

Top module: `ring_cmd_engine`

## Requirements
- R1: After reset, the control register reads a request count of 16 and the inbound write pointer reads 15. The cause register reads 0, `irq` and `req_valid` are low, and `cpl_ready` is high.
- R2: The engine reads unit i at byte address {inbound base high, inbound base low} + 8*i. It holds `mrd_req` and `mrd_addr` steady until `mrd_ack`.
- R3: Units are presented in index order, starting one past the last consumed index, up to and including the posted write pointer. The next index after count-1 is 0, and `req_index` carries the unit's index.
- R4: `req_addr` equals unit bits 31:0 with bits 4:0 cleared (32-byte alignment), and `req_size` equals unit bits 63:32.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_size` and `req_index` stay unchanged.
- R6: When every posted unit has been consumed, no memory read is issued and `req_valid` stays low.
- R7: A write to the control register loads the request count from bits 7:0. It also sets the write pointer, the read index and the outbound index to count-1, so the next unit used on each ring is index 0.
- R8: Each accepted completion writes `cpl_flag` | 0x80000000 to {outbound base} + 4*j, where j is the next outbound index, using the same wrap rule as R3.
- R9: After the outbound unit write is acknowledged, the engine writes j, zero-extended, to the shadow base address. Only then is the completion finished, and `cpl_ready` is low in between.
- R10: A finished completion sets cause bit 0. `irq` is high exactly when a cause bit and its enable bit (enable register bits 1:0) are both set.
- R11: Writing 1 to a cause bit clears it, and writing 0 leaves it unchanged.
- R12: A host write to the command register drives `cpu_msg_valid` high for one cycle with the written value on `cpu_msg_data`. The register reads back the same value.
- R13: A CPU reply write stores the value in the reply register and sets cause bit 1. A host write to the reply register has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 20 | Host register byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr (combinational) |
| mrd_req | output | 1 | Inbound unit read request |
| mrd_addr | output | 64 | Inbound unit read address |
| mrd_ack | input | 1 | Read accepted, data valid this cycle |
| mrd_data | input | 64 | Unit word: size 63:32, address 31:0 |
| req_valid | output | 1 | Request available to processing side |
| req_ready | input | 1 | Processing side takes request |
| req_addr | output | 32 | Aligned request address |
| req_size | output | 32 | Request size |
| req_index | output | 8 | Inbound unit index |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion accepted |
| cpl_flag | input | 32 | Request flag of completed request |
| mwr_req | output | 1 | Memory write request |
| mwr_addr | output | 64 | Memory write address |
| mwr_data | output | 32 | Memory write data |
| mwr_ack | input | 1 | Memory write accepted |
| cpu_msg_valid | output | 1 | New host command pulse |
| cpu_msg_data | output | 32 | Host command value |
| cpu_reply_we | input | 1 | CPU reply write strobe |
| cpu_reply_data | input | 32 | CPU reply value |
| irq | output | 1 | Host interrupt |

## Verification
If the read index is wrong, the next fetch goes to the wrong unit address, and the first presented request after a pointer post shows the wrong `req_index`, address and size. This is visible within a few cycles of the post. A wrong outbound index or wrap rule shows at the next completion, both in the unit write address and in the shadow value, one write apart. A cause or enable fault shows on `irq` and in the cause readback one cycle after the shadow write finishes or the reply arrives.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam logic [19:0] OFS_IN_LO  = 20'h04000;
  localparam logic [19:0] OFS_IN_HI  = 20'h04004;
  localparam logic [19:0] OFS_WP     = 20'h04018;
  localparam logic [19:0] OFS_CTRL   = 20'h0402C;
  localparam logic [19:0] OFS_OB_LO  = 20'h04050;
  localparam logic [19:0] OFS_OB_HI  = 20'h04054;
  localparam logic [19:0] OFS_SH_LO  = 20'h04058;
  localparam logic [19:0] OFS_SH_HI  = 20'h0405C;
  localparam logic [19:0] OFS_CAUSE  = 20'h04088;
  localparam logic [19:0] OFS_EN     = 20'h0408C;
  localparam logic [19:0] OFS_MSG    = 20'h10400;
  localparam logic [19:0] OFS_REPLY  = 20'h10420;
  localparam logic [31:0] HOST_MASK  = 32'h8000_0000;

  // next ring index with wrap at the programmed count
  function automatic logic [15:0] idx_next(input logic [15:0] cur, input logic [15:0] cnt);
    return (cur + 16'd1 >= cnt) ? 16'd0 : cur + 16'd1;
  endfunction

  // base + index * 2^shift
  function automatic logic [63:0] unit_addr(input logic [63:0] base, input logic [15:0] idx,
                                            input int unsigned shift);
    return base + ({48'd0, idx} << shift);
  endfunction
endpackage

// File: rtl/rce_inbound.sv
module rce_inbound #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IDXW-1:0] load_count,
  input  logic [IDXW-1:0] count,
  input  logic [IDXW-1:0] wp,
  input  logic [63:0]     base,
  output logic            mrd_req,
  output logic [63:0]     mrd_addr,
  input  logic            mrd_ack,
  input  logic [63:0]     mrd_data,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [31:0]     req_addr,
  output logic [31:0]     req_size,
  output logic [IDXW-1:0] req_index
);
  typedef enum logic [1:0] {I_IDLE, I_FETCH, I_HOLD} ist_t;
  ist_t            st;
  logic [IDXW-1:0] rd_idx, nxt;

  assign nxt      = IDXW'(rce_pkg::idx_next(16'(rd_idx), 16'(count)));
  assign mrd_req  = (st == I_FETCH);
  assign mrd_addr = rce_pkg::unit_addr(base, 16'(nxt), 3);
  assign req_valid = (st == I_HOLD);
  assign req_index = nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= I_IDLE;
      rd_idx   <= IDXW'(15);
      req_addr <= '0;
      req_size <= '0;
    end else if (load) begin
      st     <= I_IDLE;
      rd_idx <= load_count - 1'b1;
    end else begin
      unique case (st)
        I_IDLE:  if (rd_idx != wp) st <= I_FETCH;
        I_FETCH: if (mrd_ack) begin
          req_addr <= mrd_data[31:0] & ~32'h1F;
          req_size <= mrd_data[63:32];
          st       <= I_HOLD;
        end
        I_HOLD:  if (req_ready) begin
          rd_idx <= nxt;
          st     <= I_IDLE;
        end
        default: st <= I_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rce_outbound.sv
module rce_outbound #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IDXW-1:0] load_count,
  input  logic [IDXW-1:0] count,
  input  logic [63:0]     ob_base,
  input  logic [63:0]     sh_base,
  input  logic            cpl_valid,
  output logic            cpl_ready,
  input  logic [31:0]     cpl_flag,
  output logic            mwr_req,
  output logic [63:0]     mwr_addr,
  output logic [31:0]     mwr_data,
  input  logic            mwr_ack,
  output logic            done,
  output logic            sh_phase
);
  typedef enum logic [1:0] {O_IDLE, O_UNIT, O_SHADOW} ost_t;
  ost_t            st;
  logic [IDXW-1:0] out_idx, nxt_q;
  logic [31:0]     flag_q;

  assign cpl_ready = (st == O_IDLE);
  assign mwr_req   = (st == O_UNIT) || (st == O_SHADOW);
  assign sh_phase  = (st == O_SHADOW);
  assign mwr_addr  = sh_phase ? sh_base : rce_pkg::unit_addr(ob_base, 16'(nxt_q), 2);
  assign mwr_data  = sh_phase ? 32'(nxt_q) : flag_q;
  assign done      = sh_phase && mwr_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= O_IDLE;
      out_idx <= IDXW'(15);
      nxt_q   <= '0;
      flag_q  <= '0;
    end else if (load) begin
      st      <= O_IDLE;
      out_idx <= load_count - 1'b1;
    end else begin
      unique case (st)
        O_IDLE: if (cpl_valid) begin
          flag_q <= cpl_flag | rce_pkg::HOST_MASK;
          nxt_q  <= IDXW'(rce_pkg::idx_next(16'(out_idx), 16'(count)));
          st     <= O_UNIT;
        end
        O_UNIT:   if (mwr_ack) st <= O_SHADOW;
        O_SHADOW: if (mwr_ack) begin
          out_idx <= nxt_q;
          st      <= O_IDLE;
        end
        default: st <= O_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_cmd_engine.sv
module ring_cmd_engine #(
  parameter int AW        = 20,
  parameter int IDXW      = 8,
  parameter int DEF_COUNT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mrd_req,
  output logic [63:0]     mrd_addr,
  input  logic            mrd_ack,
  input  logic [63:0]     mrd_data,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [31:0]     req_addr,
  output logic [31:0]     req_size,
  output logic [IDXW-1:0] req_index,
  input  logic            cpl_valid,
  output logic            cpl_ready,
  input  logic [31:0]     cpl_flag,
  output logic            mwr_req,
  output logic [63:0]     mwr_addr,
  output logic [31:0]     mwr_data,
  input  logic            mwr_ack,
  output logic            cpu_msg_valid,
  output logic [31:0]     cpu_msg_data,
  input  logic            cpu_reply_we,
  input  logic [31:0]     cpu_reply_data,
  output logic            irq
);
  localparam int NCAUSE = 2;

  logic [31:0]       in_lo, in_hi, ob_lo, ob_hi, sh_lo, sh_hi, msg_q, reply_q;
  logic [IDXW-1:0]   count_q, wp_q, new_count;
  logic [NCAUSE-1:0] cause_q, en_q, cause_set, cause_clr;
  logic              msg_pulse, load, ob_done, sh_phase;

  assign new_count = reg_wdata[IDXW-1:0];
  assign load      = reg_we && (reg_addr == AW'(rce_pkg::OFS_CTRL));
  assign cause_clr = (reg_we && reg_addr == AW'(rce_pkg::OFS_CAUSE)) ? reg_wdata[NCAUSE-1:0] : '0;
  assign cause_set = {cpu_reply_we, ob_done};
  assign irq       = |(cause_q & en_q);
  assign cpu_msg_valid = msg_pulse;
  assign cpu_msg_data  = msg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {in_lo, in_hi, ob_lo, ob_hi, sh_lo, sh_hi} <= '0;
      msg_q     <= '0;
      reply_q   <= '0;
      count_q   <= IDXW'(DEF_COUNT);
      wp_q      <= IDXW'(DEF_COUNT - 1);
      cause_q   <= '0;
      en_q      <= '0;
      msg_pulse <= 1'b0;
    end else begin
      msg_pulse <= 1'b0;
      cause_q   <= (cause_q & ~cause_clr) | cause_set;
      if (cpu_reply_we) reply_q <= cpu_reply_data;
      if (reg_we) begin
        unique case (reg_addr)
          AW'(rce_pkg::OFS_IN_LO): in_lo <= reg_wdata;
          AW'(rce_pkg::OFS_IN_HI): in_hi <= reg_wdata;
          AW'(rce_pkg::OFS_OB_LO): ob_lo <= reg_wdata;
          AW'(rce_pkg::OFS_OB_HI): ob_hi <= reg_wdata;
          AW'(rce_pkg::OFS_SH_LO): sh_lo <= reg_wdata;
          AW'(rce_pkg::OFS_SH_HI): sh_hi <= reg_wdata;
          AW'(rce_pkg::OFS_WP):    wp_q  <= reg_wdata[IDXW-1:0];
          AW'(rce_pkg::OFS_CTRL): begin
            count_q <= new_count;
            wp_q    <= new_count - 1'b1;
          end
          AW'(rce_pkg::OFS_EN):    en_q  <= reg_wdata[NCAUSE-1:0];
          AW'(rce_pkg::OFS_MSG): begin
            msg_q     <= reg_wdata;
            msg_pulse <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      AW'(rce_pkg::OFS_IN_LO): reg_rdata = in_lo;
      AW'(rce_pkg::OFS_IN_HI): reg_rdata = in_hi;
      AW'(rce_pkg::OFS_OB_LO): reg_rdata = ob_lo;
      AW'(rce_pkg::OFS_OB_HI): reg_rdata = ob_hi;
      AW'(rce_pkg::OFS_SH_LO): reg_rdata = sh_lo;
      AW'(rce_pkg::OFS_SH_HI): reg_rdata = sh_hi;
      AW'(rce_pkg::OFS_WP):    reg_rdata = 32'(wp_q);
      AW'(rce_pkg::OFS_CTRL):  reg_rdata = 32'(count_q);
      AW'(rce_pkg::OFS_CAUSE): reg_rdata = 32'(cause_q);
      AW'(rce_pkg::OFS_EN):    reg_rdata = 32'(en_q);
      AW'(rce_pkg::OFS_MSG):   reg_rdata = msg_q;
      AW'(rce_pkg::OFS_REPLY): reg_rdata = reply_q;
      default:                 reg_rdata = '0;
    endcase
  end

  rce_inbound #(.IDXW(IDXW)) u_in (
    .clk, .rst_n, .load, .load_count(new_count), .count(count_q), .wp(wp_q),
    .base({in_hi, in_lo}), .mrd_req, .mrd_addr, .mrd_ack, .mrd_data,
    .req_valid, .req_ready, .req_addr, .req_size, .req_index
  );

  rce_outbound #(.IDXW(IDXW)) u_out (
    .clk, .rst_n, .load, .load_count(new_count), .count(count_q),
    .ob_base({ob_hi, ob_lo}), .sh_base({sh_hi, sh_lo}),
    .cpl_valid, .cpl_ready, .cpl_flag, .mwr_req, .mwr_addr, .mwr_data, .mwr_ack,
    .done(ob_done), .sh_phase
  );
endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
  parameter int AW   = 20,
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic            mrd_req,
  input logic [63:0]     mrd_addr,
  input logic            mrd_ack,
  input logic            req_valid,
  input logic            req_ready,
  input logic [31:0]     req_addr,
  input logic [IDXW-1:0] req_index,
  input logic            mwr_req,
  input logic [31:0]     mwr_data,
  input logic            sh_phase,
  input logic            ob_done,
  input logic [1:0]      cause_q,
  input logic [1:0]      en_q,
  input logic [IDXW-1:0] count_q,
  input logic            cpu_msg_valid,
  input logic            irq
);
  assert_rdhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && !mrd_ack |=> mrd_req && $stable(mrd_addr));
  assert_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[4:0] == 5'd0);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_index));
  assert_shadow_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sh_phase && mwr_req |-> mwr_data < 32'(count_q));
  assert_cause_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ob_done |=> cause_q[0]);
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == 2'b00 |-> !irq);
  assert_msg_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_msg_valid |-> $past(reg_we && reg_addr == AW'(rce_pkg::OFS_MSG)));
endmodule

bind ring_cmd_engine rce_checker #(.AW(AW), .IDXW(IDXW)) u_rce_chk (
  .clk, .rst_n, .reg_we, .reg_addr, .mrd_req, .mrd_addr, .mrd_ack,
  .req_valid, .req_ready, .req_addr, .req_index, .mwr_req, .mwr_data,
  .sh_phase, .ob_done, .cause_q, .en_q, .count_q, .cpu_msg_valid, .irq
);

// File: tb/test_ring_cmd_engine.sv
module test_ring_cmd_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [19:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mrd_req, mrd_ack, req_valid, req_ready = 1'b0;
  logic [63:0] mrd_addr, mrd_data, mwr_addr;
  logic [31:0] req_addr, req_size, cpl_flag = '0, mwr_data, cpu_msg_data, cpu_reply_data = '0;
  logic [7:0]  req_index;
  logic        cpl_valid = 1'b0, cpl_ready, mwr_req, mwr_ack, cpu_msg_valid;
  logic        cpu_reply_we = 1'b0, irq, stall = 1'b0;

  int checks = 0, fails = 0, rd_hs = 0, msg_seen = 0;
  logic [31:0] msg_val;
  logic [63:0] wa[$];
  logic [31:0] wd[$];
  int rin = 15, rout = 15, wp = 15, cnt = 16;
  localparam logic [63:0] IN_BASE = 64'h0000_0001_0000_1000;
  localparam logic [63:0] OB_BASE = 64'h0000_0000_0000_2000;
  localparam logic [63:0] SH_BASE = 64'h0000_0002_0000_3000;

  always #2.5 clk = ~clk;

  ring_cmd_engine i_ring_cmd_engine (.*);

  function automatic logic [63:0] unit_word(input logic [63:0] a);
    return {a[31:0] ^ 32'h0000_0BAD, a[31:0] * 32'd3 + 32'h77};
  endfunction
  function automatic int bnext(input int i, input int c);
    return (i + 1 >= c) ? 0 : i + 1;
  endfunction

  assign mrd_ack  = mrd_req & ~stall;
  assign mrd_data = unit_word(mrd_addr);
  assign mwr_ack  = mwr_req & ~stall;

  always @(negedge clk) stall <= ($urandom % 4) == 0;
  always @(posedge clk) begin
    if (mrd_req && mrd_ack) rd_hs++;
    if (mwr_req && mwr_ack) begin wa.push_back(mwr_addr); wd.push_back(mwr_data); end
    if (cpu_msg_valid) begin msg_seen++; msg_val = cpu_msg_data; end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5 d = reg_rdata;
  endtask

  task automatic consume(input int n);
    for (int k = 0; k < n; k++) begin
      logic [63:0] ua, w;
      rin = bnext(rin, cnt);
      ua = IN_BASE + 64'(rin) * 8;
      w = unit_word(ua);
      @(negedge clk);
      while (!req_valid) @(negedge clk);
      chk("R3 index", 64'(req_index), 64'(rin));
      chk("R4 addr", 64'(req_addr), 64'(w[31:0] & ~32'h1F));
      chk("R4 size", 64'(req_size), 64'(w[63:32]));
      repeat ($urandom % 3) @(negedge clk);
      chk("R5 held", {req_valid, req_index}, {1'b1, 8'(rin)});
      req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
    end
  endtask

  task automatic complete(input logic [31:0] f);
    int base_n = wa.size();
    rout = bnext(rout, cnt);
    @(negedge clk); cpl_flag = f; cpl_valid = 1'b1;
    while (!cpl_ready) @(negedge clk);
    @(negedge clk); cpl_valid = 1'b0;
    chk("R9 busy", 64'(cpl_ready), 64'(0));
    while (wa.size() < base_n + 2) @(negedge clk);
    chk("R8 unit addr", wa[base_n], OB_BASE + 64'(rout) * 4);
    chk("R8 unit data", 64'(wd[base_n]), 64'(f | 32'h8000_0000));
    chk("R9 shadow addr", wa[base_n + 1], SH_BASE);
    chk("R9 shadow data", 64'(wd[base_n + 1]), 64'(rout));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int h;
    void'($urandom(32'd17));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(20'h0402C, v); chk("R1 count", 64'(v), 64'd16);
    rd(20'h04018, v); chk("R1 wp", 64'(v), 64'd15);
    rd(20'h04088, v); chk("R1 cause", 64'(v), 64'd0);
    chk("R1 outs", {irq, req_valid, cpl_ready}, 3'b001);

    wr(20'h04000, IN_BASE[31:0]); wr(20'h04004, IN_BASE[63:32]);
    wr(20'h04050, OB_BASE[31:0]); wr(20'h04054, OB_BASE[63:32]);
    wr(20'h04058, SH_BASE[31:0]); wr(20'h0405C, SH_BASE[63:32]);
    wr(20'h0408C, 32'd3);

    // R2 R3: first post, units 0..3
    wp = 3; wr(20'h04018, 32'(wp)); consume(4);
    // R6: caught up
    h = rd_hs;
    repeat (10) @(negedge clk);
    chk("R6 no fetch", {req_valid, 32'(rd_hs)}, {1'b0, 32'(h)});
    // random posts across the wrap at 16
    for (int t = 0; t < 6; t++) begin
      int n = int'($urandom % 5) + 1;
      for (int q = 0; q < n; q++) wp = bnext(wp, cnt);
      wr(20'h04018, 32'(wp)); consume(n);
    end
    // R7: reload with count 5
    cnt = 5; wr(20'h0402C, 32'd5); rin = 4; rout = 4; wp = 4;
    rd(20'h04018, v); chk("R7 wp reload", 64'(v), 64'd4);
    rd(20'h0402C, v); chk("R7 count", 64'(v), 64'd5);
    wp = 2; wr(20'h04018, 32'(wp)); consume(3);
    wp = 1; wr(20'h04018, 32'(wp)); consume(4);

    // R8 R9: completions with wrap at 5
    for (int t = 0; t < 7; t++) complete($urandom);
    complete(32'h0000_0000);
    complete(32'hFFFF_FFFF);
    rd(20'h04088, v); chk("R10 cause", 64'(v), 64'd1);
    chk("R10 irq", 64'(irq), 64'd1);
    wr(20'h04088, 32'd0);
    rd(20'h04088, v); chk("R11 zero write", 64'(v), 64'd1);
    wr(20'h04088, 32'd1);
    rd(20'h04088, v); chk("R11 cleared", 64'(v), 64'd0);
    chk("R11 irq low", 64'(irq), 64'd0);
    // R10 enable gating
    wr(20'h0408C, 32'd0);
    complete(32'h1234_5678);
    rd(20'h04088, v); chk("R10 cause masked", 64'(v), 64'd1);
    chk("R10 irq masked", 64'(irq), 64'd0);
    wr(20'h0408C, 32'd1);
    @(negedge clk); chk("R10 irq enabled", 64'(irq), 64'd1);
    wr(20'h04088, 32'd1);

    // R12 mailbox
    h = msg_seen;
    wr(20'h10400, 32'hCAFE_0042);
    @(negedge clk);
    chk("R12 pulse", 64'(msg_seen - h), 64'd1);
    chk("R12 data", 64'(msg_val), 64'h0000_0000_CAFE_0042);
    rd(20'h10400, v); chk("R12 readback", 64'(v), 64'h0000_0000_CAFE_0042);
    // R13 reply
    wr(20'h0408C, 32'd2);
    @(negedge clk); cpu_reply_we = 1'b1; cpu_reply_data = 32'hCAFE_0042;
    @(negedge clk); cpu_reply_we = 1'b0;
    rd(20'h10420, v); chk("R13 reply", 64'(v), 64'h0000_0000_CAFE_0042);
    rd(20'h04088, v); chk("R13 cause", 64'(v), 64'd2);
    chk("R13 irq", 64'(irq), 64'd1);
    wr(20'h10420, 32'h0BAD_BEEF);
    rd(20'h10420, v); chk("R13 host write ignored", 64'(v), 64'h0000_0000_CAFE_0042);
    finish_up();
  end
endmodule